// File: doc/BRIEF.md
# Reservation and Atomic Memory Unit

This block sits beside a data cache and resolves the read-modify-write class of core memory requests against one 8-byte aligned word: load-reserve, store-conditional and atomic operations. The cache presents the word it currently holds for the address, and the block answers with the value for the core. When the request writes memory, it also returns the merged word and a byte mask for the cache to store. It owns the single link reservation, made of a valid bit and a line address. A dedicated clear pulse drops the reservation, for example when commit takes a trap. Eviction or invalidation of the reserved line also drops it.

Store-conditional data and byte enables arrive already placed at their byte lanes in the 8-byte word. Atomic operands arrive as raw register values, and the block aligns them itself using address bit 2 for 32-bit operations. Results appear one clock after the request on registered outputs.

Top module: `resv_amo_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `resp_valid` and `wr_en` are 0 and no reservation is held. A store-conditional issued straight after reset therefore fails.
- R2: Operation codes on `req_op` are 0 load-reserve, 1 store-conditional, 2 atomic and 3 no operation. A valid request of codes 0 to 2 gives `resp_valid`=1 exactly one clock later. Code 3, or an idle cycle, gives `resp_valid`=0 and `wr_en`=0.
- R3: A load-reserve responds with the unshifted `mem_word` and does not write. It sets the reservation to line `req_addr[ADDR_W-1:LINE_OFF_W]`.
- R4: A store-conditional succeeds when all three hold: a reservation is valid, its line equals the request line, and `req_line_hit`=1. It then responds 0, asserts `wr_en`, and passes `req_be` and `req_wdata` through unchanged as `wr_be` and `wr_data`.
- R5: A store-conditional that fails responds 1 and does not write. Failure covers no reservation, a different line, and a line absent from the cache.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails.
- R7: A `resv_clear` pulse clears the reservation. In the same cycle it overrides a load-reserve, and it makes a store-conditional fail.
- R8: When `evict_valid`=1 and `evict_line` equals the reserved line, the reservation is cleared. If `evict_line` equals the line of a load-reserve in the same cycle, that load-reserve sets nothing. Evicting any other line has no effect.
- R9: A 64-bit atomic (`req_amo_dword`=1) responds with the old `mem_word` and writes f(old, `req_wdata`) with `wr_be`=8'hFF.
- R10: A 32-bit atomic takes its operand from `req_wdata[31:0]`. It acts on bytes 0-3 (`wr_be`=8'h0F) when `req_addr[2]`=0, and on bytes 4-7 (`wr_be`=8'hF0) when it is 1. It responds with the old 32-bit value sign-extended to 64 bits.
- R11: `req_amo_func` codes are 0 add, 1 swap, 2 and, 3 or, 4 xor, 5 signed min, 6 signed max, 7 unsigned min and 8 unsigned max. Comparisons use the operation width.
- R12: An atomic with a code above 8 writes the old value back unchanged. Atomics leave the reservation untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (R2) |
| req_addr | input | ADDR_W | Physical address |
| req_be | input | 8 | Pre-shifted byte enable (store-conditional) |
| req_wdata | input | 64 | Store-conditional data (aligned) or atomic operand (raw) |
| req_amo_func | input | 4 | Atomic function code (R11) |
| req_amo_dword | input | 1 | 1 = 64-bit atomic, 0 = 32-bit |
| req_line_hit | input | 1 | Line is present in the cache |
| mem_word | input | 64 | Current cached 8-byte word |
| resv_clear | input | 1 | Drop the reservation |
| evict_valid | input | 1 | A line leaves the cache |
| evict_line | input | ADDR_W-LINE_OFF_W | Line address leaving |
| resp_valid | output | 1 | Response for the core |
| resp_data | output | 64 | Response value |
| wr_en | output | 1 | Cache word write required |
| wr_data | output | 64 | Merged word to write |
| wr_be | output | 8 | Byte mask of the write |

## Verification
The bench builds the block with its default 40-bit address and 64-byte lines. At that size a line address is 34 bits, so line comparison runs across a wide field. Two addresses differing only in bit 6 land on separate lines, and two that differ only in bit 3 share one. That makes both same-line and different-line store-conditionals easy to reach. Word-mode atomics use operands whose 32-bit and 64-bit signed orderings disagree, which tests the width-dependent comparison.

// File: rtl/resv_amo_pkg.sv
package resv_amo_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int HALF_W     = WORD_W / 2;

  typedef enum logic [1:0] {
    OP_LR   = 2'd0,
    OP_SC   = 2'd1,
    OP_AMO  = 2'd2,
    OP_NONE = 2'd3
  } mem_op_e;

  typedef enum logic [3:0] {
    AF_ADD  = 4'd0,
    AF_SWAP = 4'd1,
    AF_AND  = 4'd2,
    AF_OR   = 4'd3,
    AF_XOR  = 4'd4,
    AF_MIN  = 4'd5,
    AF_MAX  = 4'd6,
    AF_MINU = 4'd7,
    AF_MAXU = 4'd8
  } amo_fn_e;
endpackage

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int LINE_W = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_set,
  input  logic              sc_seen,
  input  logic              clr,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_hit,
  output logic              sc_ok
);
  logic              held_q;
  logic [LINE_W-1:0] line_q;
  logic              kill_held;
  logic              kill_new;

  // a clear or an eviction of the held line drops it this cycle
  assign kill_held = clr | (evict_valid & held_q & (evict_line == line_q));
  // eviction of the line a same-cycle load-reserve would reserve
  assign kill_new  = clr | (evict_valid & (evict_line == req_line));
  assign sc_ok     = held_q & ~kill_held & (line_q == req_line) & req_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      line_q <= '0;
    end else if (kill_held || sc_seen || (lr_set && kill_new)) begin
      held_q <= 1'b0;
    end else if (lr_set) begin
      held_q <= 1'b1;
      line_q <= req_line;
    end
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import resv_amo_pkg::*;
(
  input  logic [3:0]        fn,
  input  logic              dword,
  input  logic [WORD_W-1:0] old_val,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] sa, sb, ua, ub;
  logic              lt_s, lt_u;

  always_comb begin
    if (dword) begin
      sa = old_val;
      sb = opnd;
      ua = old_val;
      ub = opnd;
    end else begin
      sa = {{HALF_W{old_val[HALF_W-1]}}, old_val[HALF_W-1:0]};
      sb = {{HALF_W{opnd[HALF_W-1]}}, opnd[HALF_W-1:0]};
      ua = {{HALF_W{1'b0}}, old_val[HALF_W-1:0]};
      ub = {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};
    end
    lt_s = $signed(sa) < $signed(sb);
    lt_u = ua < ub;
    case (amo_fn_e'(fn))
      AF_ADD:  result = sa + sb;
      AF_SWAP: result = sb;
      AF_AND:  result = sa & sb;
      AF_OR:   result = sa | sb;
      AF_XOR:  result = sa ^ sb;
      AF_MIN:  result = lt_s ? sa : sb;
      AF_MAX:  result = lt_s ? sb : sa;
      AF_MINU: result = lt_u ? ua : ub;
      AF_MAXU: result = lt_u ? ub : ua;
      default: result = sa;
    endcase
  end
endmodule

// File: rtl/resv_amo_unit.sv
module resv_amo_unit
  import resv_amo_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_OFF_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [1:0]                   req_op,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [WORD_BYTES-1:0]        req_be,
  input  logic [WORD_W-1:0]            req_wdata,
  input  logic [3:0]                   req_amo_func,
  input  logic                         req_amo_dword,
  input  logic                         req_line_hit,
  input  logic [WORD_W-1:0]            mem_word,
  input  logic                         resv_clear,
  input  logic                         evict_valid,
  input  logic [ADDR_W-LINE_OFF_W-1:0] evict_line,
  output logic                         resp_valid,
  output logic [WORD_W-1:0]            resp_data,
  output logic                         wr_en,
  output logic [WORD_W-1:0]            wr_data,
  output logic [WORD_BYTES-1:0]        wr_be
);
  localparam int LINE_W   = ADDR_W - LINE_OFF_W;
  localparam int HALF_BIT = $clog2(WORD_BYTES) - 1;
  localparam int HALF_B   = WORD_BYTES / 2;

  mem_op_e           op;
  logic [LINE_W-1:0] req_line;
  logic              is_lr, is_sc, is_amo;
  logic              sc_ok;
  logic [HALF_W-1:0] old_half;
  logic [WORD_W-1:0] alu_old, alu_res;
  logic [WORD_W-1:0] amo_wdata, amo_resp;
  logic [WORD_BYTES-1:0] amo_be;

  assign op       = mem_op_e'(req_op);
  assign req_line = req_addr[ADDR_W-1:LINE_OFF_W];
  assign is_lr    = req_valid & (op == OP_LR);
  assign is_sc    = req_valid & (op == OP_SC);
  assign is_amo   = req_valid & (op == OP_AMO);

  resv_tracker #(.LINE_W(LINE_W)) u_resv (
    .clk        (clk),
    .rst        (rst),
    .lr_set     (is_lr),
    .sc_seen    (is_sc),
    .clr        (resv_clear),
    .evict_valid(evict_valid),
    .evict_line (evict_line),
    .req_line   (req_line),
    .req_hit    (req_line_hit),
    .sc_ok      (sc_ok)
  );

  assign old_half = req_addr[HALF_BIT] ? mem_word[WORD_W-1:HALF_W] : mem_word[HALF_W-1:0];
  assign alu_old  = req_amo_dword ? mem_word : {{HALF_W{1'b0}}, old_half};

  amo_alu u_alu (
    .fn     (req_amo_func),
    .dword  (req_amo_dword),
    .old_val(alu_old),
    .opnd   (req_wdata),
    .result (alu_res)
  );

  always_comb begin
    if (req_amo_dword) begin
      amo_wdata = alu_res;
      amo_be    = '1;
      amo_resp  = mem_word;
    end else begin
      amo_wdata = {alu_res[HALF_W-1:0], alu_res[HALF_W-1:0]};
      amo_be    = req_addr[HALF_BIT] ? {{HALF_B{1'b1}}, {HALF_B{1'b0}}}
                                     : {{HALF_B{1'b0}}, {HALF_B{1'b1}}};
      amo_resp  = {{HALF_W{old_half[HALF_W-1]}}, old_half};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      wr_be      <= '0;
    end else begin
      resp_valid <= is_lr | is_sc | is_amo;
      wr_en      <= (is_sc & sc_ok) | is_amo;
      if (is_lr) begin
        resp_data <= mem_word;
      end else if (is_sc) begin
        resp_data <= {{(WORD_W-1){1'b0}}, ~sc_ok};
        wr_data   <= req_wdata;
        wr_be     <= req_be;
      end else if (is_amo) begin
        resp_data <= amo_resp;
        wr_data   <= amo_wdata;
        wr_be     <= amo_be;
      end
    end
  end
endmodule

// File: rtl/resv_amo_chk.sv
module resv_amo_chk #(
  parameter int ADDR_W     = 40,
  parameter int LINE_OFF_W = 6
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [1:0]                   req_op,
  input logic                         req_amo_dword,
  input logic                         req_line_hit,
  input logic [63:0]                  mem_word,
  input logic                         resv_clear,
  input logic                         resp_valid,
  input logic [63:0]                  resp_data,
  input logic                         wr_en,
  input logic [7:0]                   wr_be
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> (resp_valid == ($past(req_valid) && $past(req_op) != 2'd3)));

  // R2
  write_needs_resp_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> resp_valid);

  // R3
  lr_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(req_valid) && $past(req_op) == 2'd0) |->
      (!wr_en && resp_data == $past(mem_word)));

  // R4
  sc_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(req_valid) && $past(req_op) == 2'd1) |->
      (resp_data[63:1] == '0 && (wr_en == !resp_data[0])));

  // R5
  sc_miss_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(req_valid) && $past(req_op) == 2'd1 && !$past(req_line_hit)) |->
      (resp_data == 64'd1 && !wr_en));

  // R7
  sc_clear_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(req_valid) && $past(req_op) == 2'd1 && $past(resv_clear)) |->
      (resp_data == 64'd1));

  // R9
  amo_dword_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(req_valid) && $past(req_op) == 2'd2 && $past(req_amo_dword)) |->
      (wr_en && wr_be == 8'hFF && resp_data == $past(mem_word)));

  // R10
  amo_word_be_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(req_valid) && $past(req_op) == 2'd2 && !$past(req_amo_dword)) |->
      (wr_en && $countones(wr_be) == 4));
endmodule

bind resv_amo_unit resv_amo_chk #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .req_amo_dword(req_amo_dword),
  .req_line_hit (req_line_hit),
  .mem_word     (mem_word),
  .resv_clear   (resv_clear),
  .resp_valid   (resp_valid),
  .resp_data    (resp_data),
  .wr_en        (wr_en),
  .wr_be        (wr_be)
);

// File: tb/sim_resv_amo_unit.sv
module sim_resv_amo_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int LW = 34;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_be;
  logic [63:0]   req_wdata;
  logic [3:0]    req_amo_func;
  logic          req_amo_dword;
  logic          req_line_hit;
  logic [63:0]   mem_word;
  logic          resv_clear;
  logic          evict_valid;
  logic [LW-1:0] evict_line;
  logic          resp_valid;
  logic [63:0]   resp_data;
  logic          wr_en;
  logic [63:0]   wr_data;
  logic [7:0]    wr_be;

  int checks = 0;
  int errors = 0;

  // reference reservation
  bit          m_held = 0;
  bit [LW-1:0] m_line = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_amo_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_amo_func(req_amo_func), .req_amo_dword(req_amo_dword),
    .req_line_hit(req_line_hit), .mem_word(mem_word), .resv_clear(resv_clear),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .resp_valid(resp_valid), .resp_data(resp_data), .wr_en(wr_en),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  function automatic bit [63:0] ref_fn64(input bit [3:0] f, input bit [63:0] a, input bit [63:0] b);
    longint sa = a;
    longint sb = b;
    case (f)
      0: return a + b;
      1: return b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return (sa < sb) ? a : b;
      6: return (sa > sb) ? a : b;
      7: return (a < b) ? a : b;
      8: return (a > b) ? a : b;
      default: return a;
    endcase
  endfunction

  function automatic bit [31:0] ref_fn32(input bit [3:0] f, input bit [31:0] a, input bit [31:0] b);
    int sa = a;
    int sb = b;
    case (f)
      0: return a + b;
      1: return b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return (sa < sb) ? a : b;
      6: return (sa > sb) ? a : b;
      7: return (a < b) ? a : b;
      8: return (a > b) ? a : b;
      default: return a;
    endcase
  endfunction

  task automatic fail_line(input string tag, input string what, input bit [63:0] act, input bit [63:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // drive one cycle at negedge, model it, compare at the next negedge
  task automatic step(input string tag, input bit v, input bit [1:0] op, input bit [AW-1:0] addr,
                      input bit [7:0] be, input bit [63:0] wd, input bit [3:0] fn, input bit dw,
                      input bit hit, input bit [63:0] mem, input bit clr, input bit ev,
                      input bit [LW-1:0] evl);
    bit [LW-1:0] ln = addr[AW-1:6];
    bit kill = clr || (ev && m_held && evl == m_line);
    bit kill_new = clr || (ev && evl == ln);
    bit e_rv = 0, e_we = 0, ok;
    bit [63:0] e_rd = 0, e_wd = 0;
    bit [7:0]  e_be = 0;
    bit [63:0] mask = 0;
    bit [31:0] o32, r32;
    bit ok_cmp;
    req_valid = v; req_op = op; req_addr = addr; req_be = be; req_wdata = wd;
    req_amo_func = fn; req_amo_dword = dw; req_line_hit = hit; mem_word = mem;
    resv_clear = clr; evict_valid = ev; evict_line = evl;
    if (v && op == 2'd0) begin
      e_rv = 1; e_rd = mem;
      if (kill || kill_new) m_held = 0;
      else begin m_held = 1; m_line = ln; end
    end else if (v && op == 2'd1) begin
      ok = m_held && !kill && m_line == ln && hit;
      e_rv = 1; e_rd = ok ? 64'd0 : 64'd1; e_we = ok; e_wd = wd; e_be = be;
      m_held = 0;
    end else begin
      if (kill) m_held = 0;
      if (v && op == 2'd2) begin
        e_rv = 1; e_we = 1;
        if (dw) begin
          e_rd = mem; e_wd = ref_fn64(fn, mem, wd); e_be = 8'hFF;
        end else begin
          o32 = addr[2] ? mem[63:32] : mem[31:0];
          r32 = ref_fn32(fn, o32, wd[31:0]);
          e_rd = {{32{o32[31]}}, o32};
          e_wd = addr[2] ? {r32, 32'h0} : {32'h0, r32};
          e_be = addr[2] ? 8'hF0 : 8'h0F;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; resv_clear = 0; evict_valid = 0;
    for (int i = 0; i < 8; i++) if (e_be[i]) mask[i*8 +: 8] = 8'hFF;
    checks++;
    ok_cmp = 1;
    if (resp_valid !== e_rv) begin ok_cmp = 0; fail_line(tag, "resp_valid", 64'(resp_valid), 64'(e_rv)); end
    if (wr_en !== e_we) begin ok_cmp = 0; fail_line(tag, "wr_en", 64'(wr_en), 64'(e_we)); end
    if (ok_cmp && e_rv && resp_data !== e_rd) fail_line(tag, "resp_data", resp_data, e_rd);
    if (ok_cmp && e_we && wr_be !== e_be) fail_line(tag, "wr_be", 64'(wr_be), 64'(e_be));
    if (ok_cmp && e_we && ((wr_data ^ e_wd) & mask) != 0) fail_line(tag, "wr_data", wr_data & mask, e_wd);
  endtask

  localparam bit [AW-1:0] ADR_A  = 40'h00_1234_5680;
  localparam bit [AW-1:0] ADR_A2 = 40'h00_1234_5688;
  localparam bit [AW-1:0] ADR_B  = 40'h00_1234_56C0;
  localparam bit [LW-1:0] LN_A   = ADR_A[AW-1:6];
  localparam bit [LW-1:0] LN_B   = ADR_B[AW-1:6];
  localparam bit [63:0]   M0     = 64'h8000_0001_FFFF_FFF0;

  task automatic lr(input string t, input bit [AW-1:0] a, input bit clr, input bit ev, input bit [LW-1:0] evl);
    step(t, 1, 2'd0, a, 8'h00, 64'h0, 4'd0, 1, 1, M0, clr, ev, evl);
  endtask
  task automatic sc(input string t, input bit [AW-1:0] a, input bit hit, input bit clr);
    step(t, 1, 2'd1, a, 8'h3C, 64'h0000_BEEF_CAFE_0000, 4'd0, 1, hit, M0, clr, 0, '0);
  endtask
  task automatic amo(input string t, input bit [AW-1:0] a, input bit [3:0] fn, input bit dw,
                     input bit [63:0] opnd, input bit [63:0] mem);
    step(t, 1, 2'd2, a, 8'h00, opnd, fn, dw, 1, mem, 0, 0, '0);
  endtask
  task automatic idle(input string t, input bit clr, input bit ev, input bit [LW-1:0] evl);
    step(t, 0, 2'd0, ADR_A, 8'h00, 64'h0, 4'd0, 1, 1, M0, clr, ev, evl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_op = 0; req_addr = '0; req_be = 0; req_wdata = 0;
    req_amo_func = 0; req_amo_dword = 0; req_line_hit = 0; mem_word = 0;
    resv_clear = 0; evict_valid = 0; evict_line = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (resp_valid !== 0 || wr_en !== 0)
      fail_line("R1", "reset outputs", {62'b0, resp_valid, wr_en}, 64'd0);
    rst = 0;
    sc("R1 sc after reset", ADR_A, 1, 0);
    // R2 idle and op 3
    idle("R2 idle", 0, 0, '0);
    step("R2 op none", 1, 2'd3, ADR_A, 8'hFF, 64'h1, 4'd0, 1, 1, M0, 0, 0, '0);
    // R3, R4
    lr("R3 lr", ADR_A, 0, 0, '0);
    sc("R4 sc success", ADR_A2, 1, 0);
    // R6
    sc("R6 sc after sc", ADR_A, 1, 0);
    lr("R3 lr", ADR_A, 0, 0, '0);
    sc("R5 sc other line", ADR_B, 1, 0);
    sc("R6 sc after failed sc", ADR_A, 1, 0);
    lr("R3 lr", ADR_A, 0, 0, '0);
    sc("R5 sc line absent", ADR_A, 0, 0);
    // R7
    lr("R3 lr", ADR_A, 0, 0, '0);
    idle("R7 clear pulse", 1, 0, '0);
    sc("R7 sc after clear", ADR_A, 1, 0);
    lr("R7 lr with clear", ADR_A, 1, 0, '0);
    sc("R7 sc after lr+clear", ADR_A, 1, 0);
    lr("R3 lr", ADR_A, 0, 0, '0);
    sc("R7 sc with clear", ADR_A, 1, 1);
    // R8
    lr("R3 lr", ADR_A, 0, 0, '0);
    idle("R8 evict other", 0, 1, LN_B);
    sc("R8 sc survives other evict", ADR_A, 1, 0);
    lr("R3 lr", ADR_A, 0, 0, '0);
    idle("R8 evict reserved", 0, 1, LN_A);
    sc("R8 sc after evict", ADR_A, 1, 0);
    lr("R8 lr with evict same line", ADR_A, 0, 1, LN_A);
    sc("R8 sc after lr+evict", ADR_A, 1, 0);
    // R9, R11 64-bit functions
    for (int f = 0; f < 9; f++)
      amo("R9 R11 amo64", ADR_A, 4'(f), 1, 64'hFFFF_0000_0000_0010, M0);
    // R10, R11 32-bit functions on both halves
    for (int f = 0; f < 9; f++) begin
      amo("R10 R11 amo32 low", ADR_A, 4'(f), 0, 64'h1234_5678_0000_0005, M0);
      amo("R10 R11 amo32 high", ADR_A | 40'h4, 4'(f), 0, 64'hABCD_0000_7FFF_FFFF, M0);
    end
    // R12 undefined code, and atomics keep the reservation
    amo("R12 undefined fn", ADR_A, 4'd12, 1, 64'h5, M0);
    amo("R12 undefined fn32", ADR_A | 40'h4, 4'd15, 0, 64'h5, M0);
    lr("R3 lr", ADR_A, 0, 0, '0);
    amo("R12 amo between", ADR_A, 4'd0, 1, 64'h1, M0);
    sc("R12 sc after amo", ADR_A, 1, 0);
    idle("R2 idle end", 0, 0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule